// File: doc/BRIEF.md
# Multiplexer Cascade Fitness Evaluator

This block scores one candidate circuit built from 2-to-1 multiplexers against a wanted three-input Boolean function. The candidate is described by a packed 37-bit gene string. It holds four bottom multiplexers fed by constants, two middle multiplexers and one top multiplexer. Each gene says whether its multiplexer exists, what feeds its two data inputs, and which of the variables a, b or c drives its select line. Multiplexers in the same level may use different select variables.

A one-cycle `start` captures the gene string and an 8-bit target truth table. The block then walks the eight input rows, one per clock. For each row it works out the output of the top multiplexer and counts the rows where that output equals the target bit. When the walk ends, `done` pulses for one cycle. At that point `fitness` holds the number of matching rows (0 to 8), and `perfect` shows whether all eight rows matched. A search engine outside the block issues candidates and reads back their scores.

Top module: `mux_net_fitness`

## Requirements
- R1: While `rst` is high, and after it is released, `done`, `perfect` and `fitness` are all 0.
- R2: Gene layout of the chromosome. Bottom multiplexer k (k = 0..3) uses bits [4k+3:4k]. Middle multiplexer j (j = 0..1) uses bits [16+7j+6:16+7j]. The top multiplexer uses bits [36:30]. Within each gene, the most significant bit is the presence bit.
- R3: Bottom gene {P,F,S1,S0}. With F=0 the inputs are (in0=1, in1=0). With F=1 they are (in0=0, in1=1). A present multiplexer outputs in1 when its select variable is 1 and in0 otherwise.
- R4: Select code mapping: 00 = a, 01 = b, 10 = c, 11 = a. Row r drives a = r[2], b = r[1], c = r[0].
- R5: Middle and top gene {P,Q3,Q2,Q1,Q0,S1,S0}. Q3Q2 picks in0: 00 = const 0, 01 = const 1, 10 = second lower output, 11 = first lower output. Q1Q0 picks in1: 00 = const 1, 01 = first lower output, 10 = second lower output, 11 = const 0. For middle multiplexer j, the first and second lower outputs come from bottom multiplexers 2j and 2j+1. For the top multiplexer they come from middle multiplexers 0 and 1.
- R6: A multiplexer whose presence bit is 0 outputs its in0, whatever its select variable is.
- R7: `fitness` counts the rows r (0..7) where the top multiplexer output equals `target[r]`.
- R8: `done` is high for exactly one cycle. It goes high after the eighth rising edge that follows the edge where `start` was accepted.
- R9: `perfect` is 1 after an evaluation exactly when the final `fitness` equals 8.
- R10: `chromosome` and `target` are sampled only at the edge that accepts `start`. A `start` raised during an evaluation is ignored.
- R11: After `done`, `fitness` and `perfect` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an evaluation when idle |
| chromosome | input | 37 | Packed gene string of the candidate network |
| target | input | 8 | Wanted output; bit r belongs to row r |
| done | output | 1 | One-cycle pulse when the score is final |
| fitness | output | 4 | Number of matching rows |
| perfect | output | 1 | All eight rows matched |

## Verification
Call E0 the edge that accepts `start`. `done` is due after the eighth edge past E0 and must be low in every cycle before that. `fitness` and `perfect` are read in that same cycle, and again one cycle later, when `done` must have fallen and the score must not have moved. Inputs change on falling edges and outputs are sampled on falling edges, so each check falls between two known rising edges. The bench scrambles the inputs right after E0, and in some runs it raises a second `start` in mid-walk, to show that only the values captured at E0 count.

// File: rtl/mxe_pkg.sv
package mxe_pkg;
  localparam int NUM_VARS = 3;
  localparam int ROWS     = 1 << NUM_VARS;
  localparam int CNT_W    = $clog2(ROWS + 1);
  localparam int L1_CNT   = 4;
  localparam int L2_CNT   = 2;
  localparam int L1_GW    = 4;
  localparam int UP_GW    = 7;
  localparam int L2_BASE  = L1_CNT * L1_GW;
  localparam int L3_BASE  = L2_BASE + L2_CNT * UP_GW;
  localparam int CHROM_W  = L3_BASE + UP_GW;

  typedef struct packed {
    logic                load;
    logic                accum;
    logic                last;
    logic [NUM_VARS-1:0] row;
  } mxe_strobe_t;

  // select code -> variable value for the current row
  function automatic logic pickVar(input logic [1:0] code, input logic [NUM_VARS-1:0] row);
    case (code)
      2'b01:   pickVar = row[1];
      2'b10:   pickVar = row[0];
      default: pickVar = row[2];
    endcase
  endfunction

  // upper-level multiplexer: presence, input-pair code, select code
  function automatic logic upMux(input logic [UP_GW-1:0] gene, input logic lowA,
                                 input logic lowB, input logic [NUM_VARS-1:0] row);
    logic [3:0] src;
    logic       in0;
    logic       in1;
    src = {lowB, lowA, 1'b1, 1'b0};
    case (gene[5:4])
      2'b00:   in0 = src[0];
      2'b01:   in0 = src[1];
      2'b10:   in0 = src[3];
      default: in0 = src[2];
    endcase
    case (gene[3:2])
      2'b00:   in1 = src[1];
      2'b01:   in1 = src[2];
      2'b10:   in1 = src[3];
      default: in1 = src[0];
    endcase
    upMux = (gene[UP_GW-1] & pickVar(gene[1:0], row)) ? in1 : in0;
  endfunction
endpackage

// File: rtl/mxe_network.sv
module mxe_network
  import mxe_pkg::*;
(
  input  logic [CHROM_W-1:0]  chrom,
  input  logic [NUM_VARS-1:0] row,
  output logic                netOut
);
  logic [L1_CNT-1:0] l1Out;
  logic [L2_CNT-1:0] l2Out;

  for (genvar k = 0; k < L1_CNT; k++) begin : g_l1
    logic [L1_GW-1:0] gene;
    logic             sel;
    assign gene     = chrom[k*L1_GW +: L1_GW];
    assign sel      = gene[L1_GW-1] & pickVar(gene[1:0], row);
    // in0 = ~flip, in1 = flip
    assign l1Out[k] = sel ? gene[2] : ~gene[2];
  end

  for (genvar j = 0; j < L2_CNT; j++) begin : g_l2
    assign l2Out[j] = upMux(chrom[L2_BASE + j*UP_GW +: UP_GW], l1Out[2*j], l1Out[2*j+1], row);
  end

  assign netOut = upMux(chrom[L3_BASE +: UP_GW], l2Out[0], l2Out[1], row);
endmodule

// File: rtl/mxe_ctrl.sv
module mxe_ctrl
  import mxe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output mxe_strobe_t stb,
  output logic        done
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  localparam logic [NUM_VARS-1:0] ROW_LAST = NUM_VARS'(ROWS - 1);

  state_t              state;
  logic [NUM_VARS-1:0] rowCnt;
  logic                doneReg;

  always_comb begin
    stb.load  = (state == ST_IDLE) && start;
    stb.accum = (state == ST_RUN);
    stb.last  = (state == ST_RUN) && (rowCnt == ROW_LAST);
    stb.row   = rowCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rowCnt  <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= stb.last;
      if (stb.load) begin
        state  <= ST_RUN;
        rowCnt <= '0;
      end else if (stb.accum) begin
        rowCnt <= rowCnt + NUM_VARS'(1);
        if (stb.last) state <= ST_IDLE;
      end
    end
  end

  assign done = doneReg;
endmodule

// File: rtl/mxe_datapath.sv
module mxe_datapath
  import mxe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  mxe_strobe_t        stb,
  input  logic [CHROM_W-1:0] chromosome,
  input  logic [ROWS-1:0]    target,
  output logic [CNT_W-1:0]   fitness,
  output logic               perfect
);
  logic [CHROM_W-1:0] chromReg;
  logic [ROWS-1:0]    targetReg;
  logic [CNT_W-1:0]   fitCnt;
  logic [CNT_W-1:0]   nextCnt;
  logic               perfReg;
  logic               netOut;
  logic               rowMatch;

  mxe_network u_net (
    .chrom  (chromReg),
    .row    (stb.row),
    .netOut (netOut)
  );

  assign rowMatch = (netOut == targetReg[stb.row]);
  assign nextCnt  = fitCnt + CNT_W'(rowMatch);

  always_ff @(posedge clk) begin
    if (rst) begin
      chromReg  <= '0;
      targetReg <= '0;
      fitCnt    <= '0;
      perfReg   <= 1'b0;
    end else if (stb.load) begin
      chromReg  <= chromosome;
      targetReg <= target;
      fitCnt    <= '0;
      perfReg   <= 1'b0;
    end else if (stb.accum) begin
      fitCnt <= nextCnt;
      if (stb.last) perfReg <= (nextCnt == CNT_W'(ROWS));
    end
  end

  assign fitness = fitCnt;
  assign perfect = perfReg;
endmodule

// File: rtl/mux_net_fitness.sv
module mux_net_fitness
  import mxe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CHROM_W-1:0] chromosome,
  input  logic [ROWS-1:0]    target,
  output logic               done,
  output logic [CNT_W-1:0]   fitness,
  output logic               perfect
);
  mxe_strobe_t stb;

  mxe_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .stb   (stb),
    .done  (done)
  );

  mxe_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .chromosome (chromosome),
    .target     (target),
    .fitness    (fitness),
    .perfect    (perfect)
  );
endmodule

// File: rtl/mux_net_fitness_chk.sv
module mux_net_fitness_chk
  import mxe_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic [CNT_W-1:0] fitness,
  input logic             perfect
);
  // independent edge counter from the accepted start
  logic             run;
  logic             justDone;
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      justDone <= 1'b0;
      seen     <= '0;
    end else begin
      justDone <= run && (seen == CNT_W'(ROWS - 1));
      if (!run && start) begin
        run  <= 1'b1;
        seen <= '0;
      end else if (run) begin
        seen <= seen + CNT_W'(1);
        if (seen == CNT_W'(ROWS - 1)) run <= 1'b0;
      end
    end
  end

  a_r8_done_when_due: assert property (@(posedge clk) disable iff (rst)
    done == justDone);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_perfect_full: assert property (@(posedge clk) disable iff (rst)
    perfect |-> (fitness == CNT_W'(ROWS)));

  a_r9_perfect_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(perfect) |-> done);

  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    run |=> (fitness <= $past(fitness) + CNT_W'(1)));

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> ($stable(fitness) && $stable(perfect)));

  always @(posedge clk) begin
    if (rst) begin
      a_r1_reset_outputs: assert (fitness == '0 || $past(rst) == 1'b0);
    end
  end
endmodule

bind mux_net_fitness mux_net_fitness_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .fitness (fitness),
  .perfect (perfect)
);

// File: tb/mux_net_fitness_bench.sv
module mux_net_fitness_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [36:0] chromosome;
  logic [7:0]  target;
  logic        done;
  logic [3:0]  fitness;
  logic        perfect;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_net_fitness u_mux_net_fitness (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .chromosome (chromosome),
    .target     (target),
    .done       (done),
    .fitness    (fitness),
    .perfect    (perfect)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] g1(input bit p, input bit f, input logic [1:0] s);
    return {p, f, s};
  endfunction

  function automatic logic [6:0] gu(input bit p, input logic [3:0] q, input logic [1:0] s);
    return {p, q, s};
  endfunction

  function automatic logic [36:0] pack(input logic [6:0] top, input logic [6:0] m1, input logic [6:0] m0,
                                       input logic [3:0] b3, input logic [3:0] b2,
                                       input logic [3:0] b1, input logic [3:0] b0);
    return {top, m1, m0, b3, b2, b1, b0};
  endfunction

  // R4: select mapping
  function automatic logic refVar(input logic [1:0] s, input logic [2:0] r);
    if (s == 2'b01) return r[1];
    if (s == 2'b10) return r[0];
    return r[2];
  endfunction

  // R5/R6: upper gene evaluation
  function automatic logic refUp(input logic [6:0] g, input logic first, input logic second, input logic [2:0] r);
    logic i0;
    logic i1;
    case (g[5:4])
      2'b00: i0 = 1'b0;
      2'b01: i0 = 1'b1;
      2'b10: i0 = second;
      default: i0 = first;
    endcase
    case (g[3:2])
      2'b00: i1 = 1'b1;
      2'b01: i1 = first;
      2'b10: i1 = second;
      default: i1 = 1'b0;
    endcase
    if (g[6] && refVar(g[1:0], r)) return i1;
    return i0;
  endfunction

  function automatic logic [7:0] refTable(input logic [36:0] ch);
    logic [7:0] t;
    logic [3:0] b;
    logic [1:0] m;
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] g;
        g = ch[4*k +: 4];
        b[k] = (g[3] && refVar(g[1:0], 3'(r))) ? g[2] : !g[2];
      end
      for (int j = 0; j < 2; j++)
        m[j] = refUp(ch[16 + 7*j +: 7], b[2*j], b[2*j+1], 3'(r));
      t[r] = refUp(ch[30 +: 7], m[0], m[1], 3'(r));
    end
    return t;
  endfunction

  function automatic int refFit(input logic [36:0] ch, input logic [7:0] tg);
    logic [7:0] same;
    same = ~(refTable(ch) ^ tg);
    return $countones(same);
  endfunction

  // R8/R7/R9/R10/R11: one framed evaluation
  task automatic runEval(input logic [36:0] ch, input logic [7:0] tg, input bit poke, input string req);
    bit timingOk;
    int expFit;
    logic [3:0] fitAtDone;
    logic perfAtDone;
    expFit = refFit(ch, tg);
    @(negedge clk);
    chromosome = ch; target = tg; start = 1'b1;
    @(negedge clk);
    start = 1'b0; chromosome = ~ch; target = ~tg;   // R10: post-capture changes ignored
    timingOk = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      start = (poke && i == 3);
      if (poke && i == 3) chromosome = 37'h15A5A5A5A5;
      @(negedge clk);
      if (done !== (i == 8)) timingOk = 1'b0;
    end
    start = 1'b0;
    check(timingOk, "R8", "done timing", int'(done), 1);
    check(fitness == 4'(expFit), poke ? "R10" : req, "fitness", int'(fitness), expFit);
    check(perfect == (expFit == 8), "R9", "perfect", int'(perfect), int'(expFit == 8));
    fitAtDone = fitness; perfAtDone = perfect;
    @(negedge clk);
    check(done == 1'b0, "R8", "done pulse width", int'(done), 0);
    check(fitness == fitAtDone && perfect == perfAtDone, "R11", "hold after done", int'(fitness), int'(fitAtDone));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [36:0] ch;
    logic [7:0]  tg;
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; chromosome = '0; target = '0;
    repeat (3) @(negedge clk);
    check(done == 0 && fitness == 0 && perfect == 0, "R1", "reset outputs", int'(fitness), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && fitness == 0 && perfect == 0, "R1", "after reset", int'(fitness), 0);

    // R6: all absent, top in0 = const 0 -> constant 0
    runEval('0, 8'h00, 1'b0, "R6");
    runEval('0, 8'hFF, 1'b0, "R7");
    // R4: top present, pair (0,1), select codes a, b, c, and 11 = a
    runEval(pack(gu(1, 4'b0000, 2'b00), '0, '0, '0, '0, '0, '0), 8'hF0, 1'b0, "R4");
    runEval(pack(gu(1, 4'b0000, 2'b01), '0, '0, '0, '0, '0, '0), 8'hCC, 1'b0, "R4");
    runEval(pack(gu(1, 4'b0000, 2'b10), '0, '0, '0, '0, '0, '0), 8'hAA, 1'b0, "R4");
    runEval(pack(gu(1, 4'b0000, 2'b11), '0, '0, '0, '0, '0, '0), 8'hF0, 1'b0, "R4");
    // R2/R3/R5/R6: absent top and middle with code 1111 pass bottom mux 0 (flip=1, select c)
    runEval(pack(gu(0, 4'b1111, 2'b01), '0, gu(0, 4'b1111, 2'b00), '0, '0, '0, g1(1, 1, 2'b10)), 8'hAA, 1'b0, "R5");
    // R3: flip=0 gives inverted select
    runEval(pack(gu(0, 4'b1111, 2'b00), '0, gu(0, 4'b1111, 2'b00), '0, '0, '0, g1(1, 0, 2'b01)), 8'h33, 1'b0, "R3");
    // R5: second lower outputs through in0 code 10, bottom mux 3 selecting a
    runEval(pack(gu(0, 4'b1000, 2'b00), gu(0, 4'b1000, 2'b00), '0, g1(1, 1, 2'b00), '0, '0, '0), 8'hF0, 1'b0, "R5");
    // R6: absent bottom mux ignores its select
    runEval(pack(gu(0, 4'b1111, 2'b00), '0, gu(0, 4'b1111, 2'b00), '0, '0, '0, g1(0, 1, 2'b00)), 8'h00, 1'b0, "R6");
    // R10: start during evaluation ignored
    runEval(pack(gu(1, 4'b0000, 2'b01), '0, '0, '0, '0, '0, '0), 8'hCC, 1'b1, "R10");

    for (int n = 0; n < 40; n++) begin
      ch = {5'($urandom), $urandom};
      tg = (n % 3 == 0) ? refTable(ch) : 8'($urandom);
      runEval(ch, tg, (n % 7 == 3), "R7");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule